// File: doc/BRIEF.md
# Clock Output Gate and Park Controller

This block sits at the output stage of a multi-channel clock distribution fabric. Each channel receives a source clock and drives a true pin and a companion pin. Several conditions can each stop a channel:
- a shared active-high disable pin,
- a per-channel software off bit,
- a loss-of-lock report from the PLL, when that channel opts in,
- a loss of the reference oscillator, unless a global keep bit overrides it.

A stopped channel rests at a level chosen per channel. The true pin can be inverted per channel. The companion pin either follows the true pin or is its complement.

All logic runs on one fast system clock `clk`. The source clocks and the fault and disable pins are asynchronous to it. They are resampled through synchronizer stages, and the pins are registered. Each channel selects one of two switching modes. In aligned mode, enable and disable changes wait for the falling edge of the resampled source clock, so every high and low pulse keeps at least its full half period. In immediate mode, a change lands on the next system clock edge, whatever the source phase.

Top module: `clkout_gate`

## Requirements
- R1: While `rst` is high, every `pin_true[i]` equals `park_lvl[i]` and every `pin_comp[i]` equals `park_lvl[i] ^ comp_inv[i]`; the channel state is stopped.
- R2: When `out_dis` is 1, every channel is stopped; when it is 0, it stops no channel.
- R3: `ch_off[i]` = 1 stops channel i alone and leaves other channels running.
- R4: With `pll_unlock` = 1, a channel whose `lol_park_en[i]` = 1 is stopped; a channel with `lol_park_en[i]` = 0 keeps running.
- R5: With `ref_lost` = 1 and `ref_los_keep` = 0, all channels are stopped; with `ref_los_keep` = 1 the reference loss stops none.
- R6: A stopped channel drives `pin_true[i]` = `park_lvl[i]` (0 rests low, 1 rests high).
- R7: With `sync_sw[i]` = 1, the channel changes between running and stopped only at a falling edge of its resampled source clock. No high or low pulse on either pin is shorter than the source half period.
- R8: With `sync_sw[i]` = 0, a stop request parks the pin at the next system clock edge even while the source clock is high.
- R9: `pin_comp[i]` equals `pin_true[i]` when `comp_inv[i]` = 0 and its inverse when `comp_inv[i]` = 1.
- R10: A running channel drives `pin_true[i]` = source ^ `true_inv[i]`. The inversion does not apply to the parked level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples sources and drives the output registers |
| rst | input | 1 | Synchronous active-high reset |
| src_clk | input | NUM_CH | Per-channel source clock, asynchronous |
| out_dis | input | 1 | Shared disable pin, 1 stops all channels, asynchronous |
| pll_unlock | input | 1 | PLL loss-of-lock report, asynchronous |
| ref_lost | input | 1 | Reference oscillator loss alarm, asynchronous |
| ref_los_keep | input | 1 | 1 keeps channels running during reference loss |
| ch_off | input | NUM_CH | Per-channel stop bit |
| lol_park_en | input | NUM_CH | Per-channel opt-in to stop on loss of lock |
| park_lvl | input | NUM_CH | Per-channel resting level of the true pin |
| true_inv | input | NUM_CH | Per-channel inversion of the running true pin |
| comp_inv | input | NUM_CH | Per-channel companion pin inversion |
| sync_sw | input | NUM_CH | Per-channel 1 = period-aligned switching, 0 = immediate |
| pin_true | output | NUM_CH | Registered true output pins |
| pin_comp | output | NUM_CH | Registered companion output pins |

## Verification
The case most likely to break is a stop or start request that reaches a channel in the same cycle as its source falling edge in aligned mode. In that cycle, the mode decision and the choice of output level must agree. To provoke it, four channels with different half periods run freely while a pseudo-random sequence toggles the shared disable, the per-channel off bits, the lock loss and the reference loss, so requests land on every source phase. A monitor measures every run length on both pins and flags any that is shorter than that channel's half period. Table vectors and directed steps check the parked levels and the polarities that result from each combination of disable sources.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;
  typedef struct packed {
    logic off;
    logic lol_en;
    logic park;
    logic inv;
    logic cinv;
    logic aligned;
  } chan_cfg_t;
endpackage

// File: rtl/clkout_sync.sv
module clkout_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkout_chan.sv
module clkout_chan
  import clkout_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      src_s,
  input  logic      stop_req,
  input  chan_cfg_t cfg,
  output logic      pin_q,
  output logic      comp_q
);
  logic src_prev;
  logic run_q;
  logic run_nxt;
  logic src_fall;
  logic pin_nxt;

  assign src_fall = src_prev & ~src_s;

  always_comb begin
    if (cfg.aligned) run_nxt = src_fall ? ~stop_req : run_q;
    else             run_nxt = ~stop_req;
    pin_nxt = run_nxt ? (src_s ^ cfg.inv) : cfg.park;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_prev <= 1'b0;
      run_q    <= 1'b0;
      pin_q    <= cfg.park;
      comp_q   <= cfg.park ^ cfg.cinv;
    end else begin
      src_prev <= src_s;
      run_q    <= run_nxt;
      pin_q    <= pin_nxt;
      comp_q   <= pin_nxt ^ cfg.cinv;
    end
  end

  AST_RESET_PARK: assert property (@(posedge clk)
    rst |=> (pin_q == $past(cfg.park)) && !run_q); // R1

  AST_ALIGNED_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (run_q != $past(run_q)) && $past(cfg.aligned) |-> $past(src_fall)); // R7

  AST_IMMEDIATE_PARK: assert property (@(posedge clk) disable iff (rst)
    stop_req && !cfg.aligned |=> pin_q == $past(cfg.park)); // R8

  AST_COMP_POLARITY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> comp_q == (pin_q ^ $past(cfg.cinv))); // R9
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate
  import clkout_gate_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] src_clk,
  input  logic              out_dis,
  input  logic              pll_unlock,
  input  logic              ref_lost,
  input  logic              ref_los_keep,
  input  logic [NUM_CH-1:0] ch_off,
  input  logic [NUM_CH-1:0] lol_park_en,
  input  logic [NUM_CH-1:0] park_lvl,
  input  logic [NUM_CH-1:0] true_inv,
  input  logic [NUM_CH-1:0] comp_inv,
  input  logic [NUM_CH-1:0] sync_sw,
  output logic [NUM_CH-1:0] pin_true,
  output logic [NUM_CH-1:0] pin_comp
);
  localparam int SW = NUM_CH + 3;

  logic [SW-1:0]     async_in;
  logic [SW-1:0]     async_s;
  logic [NUM_CH-1:0] src_s;
  logic              dis_s;
  logic              unlock_s;
  logic              lost_s;
  logic              ref_stop;

  assign async_in = {ref_lost, pll_unlock, out_dis, src_clk};

  clkout_sync #(.W(SW), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (async_in),
    .q   (async_s)
  );

  assign src_s    = async_s[NUM_CH-1:0];
  assign dis_s    = async_s[NUM_CH];
  assign unlock_s = async_s[NUM_CH+1];
  assign lost_s   = async_s[NUM_CH+2];
  assign ref_stop = lost_s & ~ref_los_keep;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    chan_cfg_t cfg;
    logic      stop_req;

    assign cfg.off     = ch_off[i];
    assign cfg.lol_en  = lol_park_en[i];
    assign cfg.park    = park_lvl[i];
    assign cfg.inv     = true_inv[i];
    assign cfg.cinv    = comp_inv[i];
    assign cfg.aligned = sync_sw[i];

    assign stop_req = dis_s | cfg.off | (cfg.lol_en & unlock_s) | ref_stop;

    clkout_chan i_chan (
      .clk      (clk),
      .rst      (rst),
      .src_s    (src_s[i]),
      .stop_req (stop_req),
      .cfg      (cfg),
      .pin_q    (pin_true[i]),
      .comp_q   (pin_comp[i])
    );
  end
endmodule

// File: tb/test_clkout_gate.sv
module test_clkout_gate;
  localparam int N = 4;

  typedef struct packed {
    logic       oe;
    logic       unl;
    logic       lost;
    logic       keep;
    logic [3:0] rdis;
    logic [3:0] lolen;
    logic [3:0] park;
    logic [3:0] inv;
    logic [3:0] cinv;
    logic [3:0] exp_on;
  } vec_t;

  localparam logic [27:0] VEC [9] = '{
    28'b0_0_0_0_0000_0000_0000_0000_0000_1111,
    28'b1_0_0_0_0000_0000_0101_0011_1100_0000,
    28'b0_0_0_0_0110_0000_1001_0000_0000_1001,
    28'b0_1_0_0_0000_0011_1111_0101_0000_1100,
    28'b0_1_0_0_0000_0000_0000_0000_1111_1111,
    28'b0_0_1_0_0000_0000_1010_1100_0110_0000,
    28'b0_0_1_1_0001_0000_0110_0000_0000_1110,
    28'b1_1_1_1_0000_1111_1100_1111_1010_0000,
    28'b0_1_1_1_1000_0100_0011_0110_1001_0011
  };
  localparam string TAGS [9] = '{
    "R9 R10 all run", "R2 R6 R10", "R3 R6", "R4 opt-in", "R4 opt-out",
    "R5 R9", "R5 keep", "R2 all faults", "R3 R4 R5 mix"
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src_clk = '0;
  logic         out_dis = 1'b0, pll_unlock = 1'b0, ref_lost = 1'b0, ref_los_keep = 1'b0;
  logic [N-1:0] ch_off = '0, lol_park_en = '0, park_lvl = '0, true_inv = '0;
  logic [N-1:0] comp_inv = '0, sync_sw = '0;
  logic [N-1:0] pin_true, pin_comp;

  int  n_chk = 0;
  int  n_bad = 0;
  logic         src_free = 1'b0;
  logic [N-1:0] src_man = '0;
  logic         mon_arm = 1'b0;
  int  run_t [N];
  int  run_c [N];
  int  viol  [N];
  int  edges [N];

  always #5 clk = ~clk;

  clkout_gate #(.NUM_CH(N), .SYNC_STAGES(2)) i_clkout_gate (
    .clk(clk), .rst(rst), .src_clk(src_clk), .out_dis(out_dis),
    .pll_unlock(pll_unlock), .ref_lost(ref_lost), .ref_los_keep(ref_los_keep),
    .ch_off(ch_off), .lol_park_en(lol_park_en), .park_lvl(park_lvl),
    .true_inv(true_inv), .comp_inv(comp_inv), .sync_sw(sync_sw),
    .pin_true(pin_true), .pin_comp(pin_comp)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] expect_pins(vec_t v, logic [3:0] src);
    logic [3:0] p;
    for (int i = 0; i < N; i++) p[i] = v.exp_on[i] ? (src[i] ^ v.inv[i]) : v.park[i];
    return {p ^ v.cinv, p};
  endfunction

  // source generation: channel i half period is 3+i system cycles
  initial begin
    int cnt [N];
    for (int i = 0; i < N; i++) cnt[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (src_free) begin
          cnt[i]++;
          if (cnt[i] >= 3 + i) begin
            cnt[i] = 0;
            src_clk[i] = ~src_clk[i];
          end
        end else begin
          src_clk[i] = src_man[i];
        end
      end
    end
  end

  // pulse-width monitor for R7
  initial begin
    logic [N-1:0] lp, lc;
    lp = '0; lc = '0;
    forever begin
      @(posedge clk); #1;
      for (int i = 0; i < N; i++) begin
        if (!mon_arm) begin
          run_t[i] = 1000; run_c[i] = 1000;
        end else begin
          if (pin_true[i] !== lp[i]) begin
            if (run_t[i] < 3 + i) viol[i]++;
            edges[i]++;
            run_t[i] = 1;
          end else run_t[i]++;
          if (pin_comp[i] !== lc[i]) begin
            if (run_c[i] < 3 + i) viol[i]++;
            run_c[i] = 1;
          end else run_c[i]++;
        end
      end
      lp = pin_true; lc = pin_comp;
    end
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t v;
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) begin viol[i] = 0; edges[i] = 0; end

    // R1: reset parks
    park_lvl = 4'b0101; comp_inv = 4'b0011; src_man = 4'b1111;
    tick(3);
    chk("R1 reset park", {pin_comp, pin_true}, {4'b0110, 4'b0101});
    @(negedge clk) rst = 1'b0;

    // table walk, immediate mode, static sources
    src_man = 4'b1010;
    for (int k = 0; k < 9; k++) begin
      v = vec_t'(VEC[k]);
      @(negedge clk);
      out_dis = v.oe; pll_unlock = v.unl; ref_lost = v.lost; ref_los_keep = v.keep;
      ch_off = v.rdis; lol_park_en = v.lolen; park_lvl = v.park;
      true_inv = v.inv; comp_inv = v.cinv; sync_sw = '0;
      tick(5);
      chk(TAGS[k], {pin_comp, pin_true}, expect_pins(v, src_man));
    end

    // R7 directed on channel 0: aligned mode waits for source falling edge
    @(negedge clk);
    out_dis = 0; pll_unlock = 0; ref_lost = 0; ch_off = '0; lol_park_en = '0;
    park_lvl = '0; true_inv = '0; comp_inv = '0; sync_sw = 4'b0001; src_man = 4'b0000;
    tick(5);
    @(negedge clk) src_man[0] = 1'b1;
    tick(5);
    chk("R7 running before stop", {7'b0, pin_true[0]}, 8'd1);
    @(negedge clk) ch_off[0] = 1'b1;
    tick(5);
    chk("R7 stop waits for period end", {7'b0, pin_true[0]}, 8'd1);
    @(negedge clk) src_man[0] = 1'b0;
    tick(5);
    @(negedge clk) src_man[0] = 1'b1;
    tick(5);
    chk("R7 stop applied at falling edge", {7'b0, pin_true[0]}, 8'd0);
    @(negedge clk) ch_off[0] = 1'b0;
    tick(5);
    chk("R7 start waits for period end", {7'b0, pin_true[0]}, 8'd0);
    @(negedge clk) src_man[0] = 1'b0;
    tick(5);
    @(negedge clk) src_man[0] = 1'b1;
    tick(5);
    chk("R7 start applied", {7'b0, pin_true[0]}, 8'd1);

    // R8 immediate stop while source is high
    @(negedge clk) begin sync_sw[0] = 1'b0; ch_off[0] = 1'b1; end
    tick(1);
    chk("R8 immediate park", {7'b0, pin_true[0]}, 8'd0);

    // R7 free-running stress, aligned mode on all channels
    @(negedge clk);
    ch_off = '0; sync_sw = '1; park_lvl = 4'b0110; true_inv = 4'b0101;
    comp_inv = 4'b0011; lol_park_en = 4'b1010; ref_los_keep = 0;
    src_free = 1'b1;
    tick(20);
    mon_arm = 1'b1;
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h5) out_dis = ~out_dis;
      if (lfsr[7:4] == 4'h9) ch_off = lfsr[11:8] & lfsr[15:12];
      if (lfsr[6:2] == 5'h11) pll_unlock = ~pll_unlock;
      if (lfsr[9:5] == 5'h0C) ref_lost = ~ref_lost;
      if (out_dis && lfsr[2:0] == 3'h0) out_dis = 1'b0;
    end
    mon_arm = 1'b0;
    for (int i = 0; i < N; i++) begin
      chk($sformatf("R7 no runt pulse ch%0d", i), viol[i][7:0], 8'd0);
      chk($sformatf("R7 channel toggled ch%0d", i), {7'b0, edges[i] > 20}, 8'd1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule